// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer with four word-wide registers reached through simple read and write strobes. The source clock is slowed down in two steps: first by an 8-bit programmable prescaler, then by a fixed divider that can be set to 16, 32, 64 or 128. Each tick from this chain decrements a down counter. The counter is 16 bits wide by default and 32 bits wide when `CNT_W` is set to 32.

When the count runs out, the counter reloads itself from the reload register. Depending on the enable bits, the block then raises a one-cycle reset request, sets a sticky interrupt flag, or does both. Software keeps the system alive by writing a fresh value into the count register before that happens. Any write to the clear register drops the interrupt flag. A control bit lets a debug-acknowledge input silence both outputs while a debugger holds the system.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control register reads 0 (timer stopped), the reload and count registers read all ones of the counter width, and `irq_o` and `rst_req_o` are low.
- R2: Byte offsets: 0x00 is control, 0x04 is reload, 0x08 is count, 0x0C is clear. Control fields are: bit 0 reset enable, bit 2 interrupt enable, bits [4:3] divider select, bit 5 run, bits [15:8] prescale value P, bit 16 debug mask. A read of the control register returns exactly these bits, with all other bits zero.
- R3: While running, the counter decrements once every (P+1)*D source clock cycles. D is 16, 32, 64 or 128 for divider codes 0, 1, 2 and 3.
- R4: On the tick that would take the count from 1 (or from 0) downward, the counter instead loads the reload register value. The next expiry therefore comes reload*(P+1)*D cycles later.
- R5: With reset enable set, an expiry produces a `rst_req_o` pulse of exactly one cycle. It is visible after the clock edge that is count*(P+1)*D edges after the count write edge.
- R6: With interrupt enable set, an expiry sets a flag that keeps `irq_o` high until it is cleared. With interrupt enable clear, `irq_o` stays low.
- R7: A write of any data to offset 0x0C clears the interrupt flag. A read of that offset returns 0.
- R8: A write to the count register loads the value at once and restarts the prescaler chain. Writes repeated faster than the expiry period keep both outputs low.
- R9: Clearing the run bit freezes the count, and the count read back stays the same. Both outputs are low while the bit is clear.
- R10: While the debug mask bit and `dbg_ack` are both high, both outputs are low. If either one drops, a pending interrupt shows again.
- R11: Count and reload writes keep only the low `CNT_W` bits of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock for registers and the count chain |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| dbg_ack | input | 1 | Debug-acknowledge from the processor |
| irq_o | output | 1 | Interrupt, level, sticky until cleared |
| rst_req_o | output | 1 | Reset request, one-cycle pulse |

## Verification
The bench measures the exact cycle of expiry under three prescaler and divider settings. A chain that is off by one, with P instead of P+1 or D+1 instead of D, moves the pulse by whole ticks, and the check catches that. A second expiry is timed from the reload value. A design that reused the written count, or expired one tick late at zero, would give a different interval. Steady servicing must hold off every pulse, which fails if a count write leaves the prescaler phase in place and the write lands just before a tick. The bench also covers the freeze on disable, the debug gating in both directions and the truncation of wide count writes. A design that forgot the mask term, or let the counter creep while stopped, shows the wrong value at the ports.

// File: rtl/wdog_pkg.sv
// Shared field layout for the watchdog timer.
// Assumes word-aligned byte offsets; only address bits [3:2] are decoded.
package wdog_pkg;
    localparam logic [1:0] SEL_CTRL   = 2'd0;
    localparam logic [1:0] SEL_RELOAD = 2'd1;
    localparam logic [1:0] SEL_COUNT  = 2'd2;
    localparam logic [1:0] SEL_CLEAR  = 2'd3;

    localparam int B_RST_EN  = 0;
    localparam int B_IRQ_EN  = 2;
    localparam int B_DIV_LO  = 3;
    localparam int B_RUN     = 5;
    localparam int B_PRE_LO  = 8;
    localparam int B_DBG_MSK = 16;

    typedef struct packed {
        logic       dbg_mask;
        logic [7:0] pre;
        logic       run;
        logic [1:0] div;
        logic       irq_en;
        logic       rst_en;
    } wdog_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
// Register file: control and reload storage, plus write strobes for the
// count load and the interrupt clear. Assumes one-cycle write strobes.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       sel,
    input  logic [31:0]      wdata,
    output wdog_ctrl_t       ctrl,
    output logic [CNT_W-1:0] reload,
    output logic             load,
    output logic             clr
);
    // Control and reload capture on their own write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= '0;
            reload <= '1;
        end else if (wr) begin
            if (sel == SEL_CTRL) begin
                ctrl.rst_en   <= wdata[B_RST_EN];
                ctrl.irq_en   <= wdata[B_IRQ_EN];
                ctrl.div      <= wdata[B_DIV_LO+1:B_DIV_LO];
                ctrl.run      <= wdata[B_RUN];
                ctrl.pre      <= wdata[B_PRE_LO+7:B_PRE_LO];
                ctrl.dbg_mask <= wdata[B_DBG_MSK];
            end
            if (sel == SEL_RELOAD)
                reload <= wdata[CNT_W-1:0];
        end
    end

    // Strobes decoded for the counter and the interrupt flag.
    assign load = wr && (sel == SEL_COUNT);
    assign clr  = wr && (sel == SEL_CLEAR);
endmodule

// File: rtl/wdog_prescale.sv
// Two-stage tick generator: divide by (pre+1), then by 16<<div.
// Assumes restart has priority over run; all state holds while run is low.
module wdog_prescale #(
    parameter int PRE_W = 8,
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] pre,
    input  logic [1:0]       div,
    output logic             tick
);
    logic [PRE_W-1:0] pcnt;
    logic [DIV_W-1:0] dcnt;
    logic [DIV_W-1:0] dterm;
    logic             stage1;

    // Terminal value of the fixed divider for the selected code.
    always_comb dterm = DIV_W'((8'd16 << div) - 8'd1);

    assign stage1 = run && (pcnt == pre);
    assign tick   = stage1 && (dcnt == dterm);

    // Advance both stage counters; restart clears them to phase zero.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pcnt <= '0;
            dcnt <= '0;
        end else if (run) begin
            pcnt <= stage1 ? '0 : pcnt + 1'b1;
            if (stage1)
                dcnt <= (dcnt == dterm) ? '0 : dcnt + 1'b1;
        end
    end

    p_tick_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);
endmodule

// File: rtl/wdog_counter.sv
// Down counter with direct load and automatic reload on expiry.
// Assumes load wins over a tick in the same cycle.
module wdog_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign expire = run && tick && !load && (cnt <= ONE);

    // Load, reload on expiry, or decrement on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '1;
        else if (load)
            cnt <= load_val;
        else if (expire)
            cnt <= reload;
        else if (run && tick)
            cnt <= cnt - ONE;
    end

    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt));
endmodule

// File: rtl/wdog_timer.sv
// Watchdog top: register file, tick chain, counter, output stage.
// Assumes a single clock domain; reads are combinational on bus_addr.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        dbg_ack,
    output logic        irq_o,
    output logic        rst_req_o
);
    wdog_ctrl_t       ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt;
    logic             load, clr, tick, expire;
    logic             irq_flag, rst_q, quiet;
    logic [1:0]       sel;

    assign sel = bus_addr[3:2];

    wdog_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(sel), .wdata(bus_wdata),
        .ctrl(ctrl), .reload(reload), .load(load), .clr(clr)
    );

    wdog_prescale #(.PRE_W(8), .DIV_W(7)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .restart(load),
        .pre(ctrl.pre), .div(ctrl.div), .tick(tick)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick(tick), .load(load),
        .load_val(bus_wdata[CNT_W-1:0]), .reload(reload),
        .cnt(cnt), .expire(expire)
    );

    // Sticky interrupt flag and one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
            rst_q    <= 1'b0;
        end else begin
            rst_q <= expire && ctrl.rst_en;
            if (expire && ctrl.irq_en)
                irq_flag <= 1'b1;
            else if (clr)
                irq_flag <= 1'b0;
        end
    end

    // Output gating by the run bit and the debug mask.
    assign quiet     = !ctrl.run || (ctrl.dbg_mask && dbg_ack);
    assign irq_o     = irq_flag && !quiet;
    assign rst_req_o = rst_q && !quiet;

    // Register read mux; the clear offset reads as zero.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CTRL: begin
                bus_rdata[B_RST_EN]             = ctrl.rst_en;
                bus_rdata[B_IRQ_EN]             = ctrl.irq_en;
                bus_rdata[B_DIV_LO+1:B_DIV_LO]  = ctrl.div;
                bus_rdata[B_RUN]                = ctrl.run;
                bus_rdata[B_PRE_LO+7:B_PRE_LO]  = ctrl.pre;
                bus_rdata[B_DBG_MSK]            = ctrl.dbg_mask;
            end
            SEL_RELOAD: bus_rdata = 32'(reload);
            SEL_COUNT:  bus_rdata = 32'(cnt);
            default:    bus_rdata = '0;
        endcase
    end

    p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(expire && ctrl.irq_en));
    p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(expire && ctrl.irq_en)) |=> !irq_flag);
    p_dbg_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.dbg_mask && dbg_ack) |-> (!irq_o && !rst_req_o));
    p_rst_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);
endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_ack = 1'b0;
    logic        irq_o, rst_req_o;
    int checks = 0;
    int fails = 0;
    int cyc = 0;

    wdog_timer #(.CNT_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_ack(dbg_ack),
        .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired: actual %0d cycles expected < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [31:0] mk(input logic [7:0] pre, input logic dm,
        input logic run, input logic [1:0] dv, input logic ie, input logic re);
        return {15'd0, dm, pre, 2'b00, run, dv, ie, 1'b0, re};
    endfunction

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Count cycles from the current negedge until the chosen output rises.
    task automatic measure(input bit use_irq, input int exp, input string tag);
        int c = 0;
        logic seen = 1'b0;
        while (!seen && c < exp + 64) begin
            @(posedge clk); @(negedge clk);
            c++;
            seen = use_irq ? irq_o : rst_req_o;
        end
        chk(seen && c == exp, tag, c, exp);
    endtask

    task automatic quiesce();
        wr(4'h0, 32'h0);
        wr(4'hC, 32'h0);
        dbg_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'h0, d); chk(d == 32'h0, "R1 ctrl", d, 0);
        rd(4'h4, d); chk(d == 32'hFFFF, "R1 reload", d, 32'hFFFF);
        rd(4'h8, d); chk(d == 32'hFFFF, "R1 count", d, 32'hFFFF);
        chk(!irq_o && !rst_req_o, "R1 outputs", {irq_o, rst_req_o}, 0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, d); chk(d == 32'h0001_FF3D, "R2 ctrl fields", d, 32'h0001_FF3D);
        rd(4'hC, d); chk(d == 32'h0, "R7 clear reads zero", d, 0);
        quiesce();
        wr(4'h8, 32'h0001_2345);
        rd(4'h8, d); chk(d == 32'h2345, "R11 count truncation", d, 32'h2345);
        wr(4'h4, 32'hABCD_0042);
        rd(4'h4, d); chk(d == 32'h0042, "R11 reload truncation", d, 32'h42);
    endtask

    task automatic t_reset_only();
        quiesce();
        wr(4'h0, mk(8'd0, 0, 1, 2'd0, 0, 1));
        wr(4'h8, 32'd5);
        measure(0, 80, "R3 R5 P0 div16 N5");
        @(posedge clk); @(negedge clk);
        chk(!rst_req_o, "R5 pulse one cycle", rst_req_o, 0);
        chk(!irq_o, "R6 irq off when disabled", irq_o, 0);
    endtask

    task automatic t_irq_only();
        quiesce();
        wr(4'h0, mk(8'd2, 0, 1, 2'd1, 1, 0));
        wr(4'h8, 32'd3);
        measure(1, 288, "R3 R6 P2 div32 N3");
        repeat (40) @(negedge clk);
        chk(irq_o, "R6 irq sticky", irq_o, 1);
        chk(!rst_req_o, "R5 no reset when disabled", rst_req_o, 0);
        wr(4'hC, 32'h0);
        chk(!irq_o, "R7 clear by any write", irq_o, 0);
    endtask

    task automatic t_both_reload();
        quiesce();
        wr(4'h4, 32'd4);
        wr(4'h0, mk(8'd1, 0, 1, 2'd3, 1, 1));
        wr(4'h8, 32'd2);
        measure(0, 512, "R3 P1 div128 N2");
        chk(irq_o, "R6 irq with reset", irq_o, 1);
        wr(4'hC, 32'h5A);
        wr(4'h0, mk(8'd0, 0, 1, 2'd0, 0, 1));
        wr(4'h8, 32'd2);
        measure(0, 32, "R4 first expiry");
        measure(0, 64, "R4 reload interval");
    endtask

    task automatic t_service();
        bit bad = 0;
        quiesce();
        wr(4'h4, 32'hFFFF);
        wr(4'h0, mk(8'd0, 0, 1, 2'd0, 1, 1));
        for (int k = 0; k < 6; k++) begin
            wr(4'h8, 32'd10);
            for (int j = 0; j < 150; j++) begin
                @(negedge clk);
                if (rst_req_o || irq_o) bad = 1;
            end
        end
        chk(!bad, "R8 servicing holds off expiry", bad, 0);
    endtask

    task automatic t_freeze();
        logic [31:0] a, b;
        quiesce();
        wr(4'h0, mk(8'd0, 0, 1, 2'd0, 1, 1));
        wr(4'h8, 32'd100);
        repeat (200) @(negedge clk);
        wr(4'h0, mk(8'd0, 0, 0, 2'd0, 1, 1));
        rd(4'h8, a);
        repeat (300) @(negedge clk);
        rd(4'h8, b);
        chk(a == b && a < 100, "R9 count frozen", b, a);
        wr(4'h0, mk(8'd0, 0, 1, 2'd0, 1, 0));
        wr(4'h8, 32'd1);
        measure(1, 16, "R9 setup expiry");
        wr(4'h0, mk(8'd0, 0, 0, 2'd0, 1, 0));
        chk(!irq_o, "R9 outputs low while stopped", irq_o, 0);
    endtask

    task automatic t_debug();
        quiesce();
        dbg_ack = 1'b1;
        wr(4'h0, mk(8'd0, 1, 1, 2'd0, 1, 1));
        wr(4'h8, 32'd1);
        repeat (30) @(negedge clk);
        chk(!irq_o && !rst_req_o, "R10 masked in debug", {irq_o, rst_req_o}, 0);
        dbg_ack = 1'b0;
        #1 chk(irq_o, "R10 pending shows after ack drops", irq_o, 1);
        dbg_ack = 1'b1;
        wr(4'h0, mk(8'd0, 0, 1, 2'd0, 1, 1));
        chk(irq_o, "R10 mask bit clear ignores ack", irq_o, 1);
        quiesce();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_reset_only();
        t_irq_only();
        t_both_reload();
        t_service();
        t_freeze();
        t_debug();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule